// File: doc/BRIEF.md
# Prescaled Modulus Down-Counter

This block is a 16-bit down-counter. A programmable prescaler paces it, and it has a separate load register. Software reaches it through a small word-or-byte register port. The port has three locations: the count location, a control byte and a flag byte.

The control byte picks one of two modes:

- **Modulus mode:** the counter refills itself from the load register every time it runs out. A write to the count location only changes the refill value, and the count picks that value up at the next refill.
- **One-shot mode:** a write restarts the prescaler and loads the count at once. The counter then runs down a single time and rests at zero.

Writing zero parks the counter without raising the zero flag. The block produces a zero flag, an interrupt request gated by an enable bit, and a one-cycle strobe. The strobe tells a neighbouring capture unit to latch its registers. It fires on an enabled modulus refill, and on a zero write when both latch qualifiers from that neighbour are high.

Top module: `mdc_top`

## Requirements
- R1: A synchronous active-high reset clears the count, the load register, the prescaler, the control byte and the zero flag; every readable location returns 0 and zero_flag, irq and cap_latch_pulse are 0.
- R2: A write to location 0 (bus_addr = 0) replaces the low byte when bus_be[0] is set and the high byte when bus_be[1] is set. A word write (bus_be = 2'b11) lands in one clock edge; a byte write keeps the other half of the register it targets.
- R3: Location 0 reads the live count when control bit 2 is 0 and the load register when it is 1. Location 1 reads the control byte (bit 3 always 0). Location 2 reads the zero flag in bit 0. Location 3 reads 0.
- R4: In modulus mode (control bit 1 = 1) a nonzero write to location 0 updates only the load register; the count keeps running and takes a refill at the next underflow. If the write and an underflow share an edge, the refill uses the load value from before the write.
- R5: Writing control with bit 3 = 1 copies the load register into the count on that edge (no flag); bit 3 is never stored and reads back 0.
- R6: In one-shot mode (control bit 1 = 0) a nonzero write to location 0 sets both the count and the load register and restarts the prescaler; the count then decrements to 0, sets the zero flag on arrival, and stays at 0.
- R7: A write whose resulting value is 0x0000 sets the count and the load register to 0 in either mode, restarts the prescaler, and does not set the zero flag; the count stays at 0.
- R8: cap_latch_pulse is high for the single cycle after an edge that carries a zero write while cap_latch_en and cap_buf_en are both high, or a modulus underflow with both high; otherwise it is low.
- R9: Control bits 5:4 choose a decrement every 1, 4, 8 or 16 clocks (codes 0, 1, 2, 3) while control bit 0 is 1; with bit 0 clear the count does not change and the prescaler is held at its start.
- R10: In modulus mode a tick while the count is 1 refills the count from the load register and sets the zero flag; a count of 0 is never decremented.
- R11: Writing location 2 with bit 0 = 1 (bus_be[0] set) clears the zero flag unless it is being set on the same edge; irq is high exactly when the flag and control bit 6 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register location select |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_be | input | 2 | Byte enables (bit 0 low byte, bit 1 high byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| cap_latch_en | input | 1 | Latch qualifier from the capture neighbour |
| cap_buf_en | input | 1 | Buffer qualifier from the capture neighbour |
| zero_flag | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |
| cap_latch_pulse | output | 1 | One-cycle latch strobe to the capture neighbour |

## Verification
The hardest case to reach is a modulus-mode write to the count location on the same edge as an underflow. The refill must then use the old load value while the new value is being stored. This is hard to hit because the edge depends on the prescaler phase, the count and the mode all at once.

A directed sequence reaches it by forcing a small count with the prescaler at divide-by-one and timing the write to the edge where the count is 1. Random stimulus with small write values, frequent mode and prescaler changes and occasional force-loads reaches it many more times. Byte-wise zero writes and flag-clear collisions come up the same way.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    localparam int CNT_W  = 16;
    localparam int PRE_W  = 4;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 7;

    // Prescaler divide choice, control bits 5:4
    typedef enum logic [1:0] {
        PS_DIV1  = 2'd0,
        PS_DIV4  = 2'd1,
        PS_DIV8  = 2'd2,
        PS_DIV16 = 2'd3
    } ps_sel_e;

    // Register locations
    typedef enum logic [ADDR_W-1:0] {
        LOC_COUNT = 2'd0,
        LOC_CTRL  = 2'd1,
        LOC_FLAG  = 2'd2,
        LOC_NONE  = 2'd3
    } loc_e;

    // Control byte, packed so that its bit positions match the register
    typedef struct packed {
        logic    irq_en;    // bit 6
        ps_sel_e ps_sel;    // bits 5:4
        logic    force_ld;  // bit 3, strobe only, never stored
        logic    rd_load;   // bit 2
        logic    modulus;   // bit 1
        logic    run;       // bit 0
    } ctrl_t;

    // Prescaler terminal value for each divide choice
    function automatic logic [PRE_W-1:0] ps_terminal(input ps_sel_e sel);
        logic [PRE_W-1:0] t;
        case (sel)
            PS_DIV1:  t = PRE_W'(0);
            PS_DIV4:  t = PRE_W'(3);
            PS_DIV8:  t = PRE_W'(7);
            default:  t = PRE_W'(15);
        endcase
        return t;
    endfunction

    // Control value as it is kept in the register: strobe bit dropped
    function automatic ctrl_t ctrl_store(input logic [CTRL_W-1:0] bits);
        ctrl_t c;
        c = ctrl_t'(bits);
        c.force_ld = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/mdc_prescaler.sv
module mdc_prescaler
    import mdc_pkg::*;
#(
    parameter int PRE_W = mdc_pkg::PRE_W
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    clr,
    input  ps_sel_e sel,
    output logic    tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_d;
    logic [PRE_W-1:0] term;

    assign term = PRE_W'(ps_terminal(sel));
    assign tick = run && (pre_q == term);

    always_comb begin
        if (clr || !run || tick) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/mdc_regs.sv
module mdc_regs
    import mdc_pkg::*;
#(
    parameter int CNT_W  = mdc_pkg::CNT_W,
    parameter int ADDR_W = mdc_pkg::ADDR_W,
    localparam int NB    = CNT_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [NB-1:0]     be,
    input  logic [CTRL_W-1:0] wbits,
    input  logic [CNT_W-1:0]  count_q,
    input  logic [CNT_W-1:0]  load_q,
    input  logic              flag_set,
    output ctrl_t             ctrl,
    output logic              force_ld,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  rdata,
    output logic              zero_flag,
    output logic              irq
);

    logic ctl_wr;
    logic flag_clr;
    logic flag_d;

    // Write decode
    assign cnt_wr   = wr && (addr == LOC_COUNT) && (|be);
    assign ctl_wr   = wr && (addr == LOC_CTRL)  && be[0];
    assign flag_clr = wr && (addr == LOC_FLAG)  && be[0] && wbits[0];
    assign force_ld = ctl_wr && wbits[3];

    // Control register
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctl_wr) begin
            ctrl <= ctrl_store(wbits);
        end
    end

    // Zero flag: a set on the same edge beats a clear
    always_comb begin
        flag_d = zero_flag;
        if (flag_set) begin
            flag_d = 1'b1;
        end else if (flag_clr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_flag <= 1'b0;
        end else begin
            zero_flag <= flag_d;
        end
    end

    assign irq = zero_flag && ctrl.irq_en;

    // Read multiplexer
    always_comb begin
        case (addr)
            LOC_COUNT: rdata = ctrl.rd_load ? load_q : count_q;
            LOC_CTRL:  rdata = CNT_W'(ctrl);
            LOC_FLAG:  rdata = CNT_W'(zero_flag);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdc_count_core.sv
module mdc_count_core
    import mdc_pkg::*;
#(
    parameter int CNT_W = mdc_pkg::CNT_W,
    localparam int NB   = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_wr,
    input  logic [NB-1:0]    be,
    input  logic [CNT_W-1:0] wdata,
    input  logic             modulus,
    input  logic             force_ld,
    input  logic             tick,
    input  logic             latch_ok,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] load_q,
    output logic             flag_set,
    output logic             imm_wr,
    output logic             zero_wr,
    output logic             latch_pulse
);

    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] merged;
    logic [CNT_W-1:0] count_d;
    logic [CNT_W-1:0] load_d;
    logic             pulse_d;
    logic             at_one;
    logic             at_zero;

    // A byte write lands on the register the mode writes to
    assign target = modulus ? load_q : count_q;

    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : target[8*b +: 8];
    end

    assign zero_wr = cnt_wr && (merged == '0);
    assign imm_wr  = cnt_wr && (zero_wr || !modulus);
    assign at_one  = (count_q == CNT_W'(1));
    assign at_zero = (count_q == '0);

    always_comb begin
        count_d  = count_q;
        load_d   = load_q;
        flag_set = 1'b0;
        pulse_d  = zero_wr && latch_ok;

        if (cnt_wr) begin
            load_d = merged;
        end

        if (imm_wr) begin
            count_d = merged;
        end else if (force_ld) begin
            count_d = load_q;
        end else if (tick && !at_zero) begin
            if (at_one) begin
                count_d  = modulus ? load_q : '0;
                flag_set = 1'b1;
                if (modulus && latch_ok) begin
                    pulse_d = 1'b1;
                end
            end else begin
                count_d = count_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q     <= '0;
            load_q      <= '0;
            latch_pulse <= 1'b0;
        end else begin
            count_q     <= count_d;
            load_q      <= load_d;
            latch_pulse <= pulse_d;
        end
    end

endmodule

// File: rtl/mdc_top.sv
module mdc_top
    import mdc_pkg::*;
#(
    parameter int CNT_W  = mdc_pkg::CNT_W,
    parameter int PRE_W  = mdc_pkg::PRE_W,
    parameter int ADDR_W = mdc_pkg::ADDR_W,
    localparam int NB    = CNT_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NB-1:0]     bus_be,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cap_latch_en,
    input  logic              cap_buf_en,
    output logic              zero_flag,
    output logic              irq,
    output logic              cap_latch_pulse
);

    ctrl_t            ctrl;
    logic             force_ld;
    logic             cnt_wr;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_q;
    logic             flag_set;
    logic             imm_wr;
    logic             zero_wr;
    logic             tick;
    logic             latch_ok;
    logic             run_en;
    logic             mod_en;

    assign latch_ok = cap_latch_en && cap_buf_en;
    assign run_en   = ctrl.run;
    assign mod_en   = ctrl.modulus;

    mdc_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .be        (bus_be),
        .wbits     (bus_wdata[CTRL_W-1:0]),
        .count_q   (count_q),
        .load_q    (load_q),
        .flag_set  (flag_set),
        .ctrl      (ctrl),
        .force_ld  (force_ld),
        .cnt_wr    (cnt_wr),
        .rdata     (bus_rdata),
        .zero_flag (zero_flag),
        .irq       (irq)
    );

    mdc_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run_en),
        .clr  (imm_wr),
        .sel  (ctrl.ps_sel),
        .tick (tick)
    );

    mdc_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .cnt_wr      (cnt_wr),
        .be          (bus_be),
        .wdata       (bus_wdata),
        .modulus     (mod_en),
        .force_ld    (force_ld),
        .tick        (tick),
        .latch_ok    (latch_ok),
        .count_q     (count_q),
        .load_q      (load_q),
        .flag_set    (flag_set),
        .imm_wr      (imm_wr),
        .zero_wr     (zero_wr),
        .latch_pulse (cap_latch_pulse)
    );

endmodule

// File: rtl/mdc_checker.sv
module mdc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] load_q,
    input logic             tick,
    input logic             run,
    input logic             modulus,
    input logic             force_ld,
    input logic             cnt_wr,
    input logic             zero_wr,
    input logic             zero_flag,
    input logic             latch_pulse,
    input logic             latch_ok
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (count_q == '0 && load_q == '0 && !zero_flag && !latch_pulse));

    assert_deferred_load_R4: assert property (@(posedge clk) disable iff (rst)
        (modulus && cnt_wr && !zero_wr && !tick) |=> $stable(count_q));

    assert_force_copy_R5: assert property (@(posedge clk) disable iff (rst)
        (force_ld && !cnt_wr) |=> (count_q == $past(load_q)));

    assert_oneshot_rest_R6: assert property (@(posedge clk) disable iff (rst)
        (!modulus && count_q == '0 && !cnt_wr && !force_ld) |=> (count_q == '0));

    assert_zero_park_R7: assert property (@(posedge clk) disable iff (rst)
        zero_wr |=> (count_q == '0 && !$rose(zero_flag)));

    assert_zero_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (zero_wr && latch_ok) |=> latch_pulse);

    assert_halted_R9: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr && !force_ld) |=> $stable(count_q));

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_flag) |-> ($past(count_q) == CNT_W'(1) && $past(tick)));

endmodule

bind mdc_top mdc_checker #(.CNT_W(CNT_W)) u_mdc_chk (
    .clk         (clk),
    .rst         (rst),
    .count_q     (count_q),
    .load_q      (load_q),
    .tick        (tick),
    .run         (run_en),
    .modulus     (mod_en),
    .force_ld    (force_ld),
    .cnt_wr      (cnt_wr),
    .zero_wr     (zero_wr),
    .zero_flag   (zero_flag),
    .latch_pulse (cap_latch_pulse),
    .latch_ok    (latch_ok)
);

// File: tb/mdc_top_test.sv
module mdc_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        le = 1'b0;
    logic        bf = 1'b0;
    logic        zero_flag;
    logic        irq;
    logic        pulse;

    always #10 clk = ~clk;   // 50 MHz

    mdc_top uut (
        .clk             (clk),
        .rst             (rst),
        .bus_addr        (bus_addr),
        .bus_wr          (bus_wr),
        .bus_be          (bus_be),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .cap_latch_en    (le),
        .cap_buf_en      (bf),
        .zero_flag       (zero_flag),
        .irq             (irq),
        .cap_latch_pulse (pulse)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state, written from the requirements
    logic [15:0] m_cnt = 16'd0, m_load = 16'd0, t_mv = 16'd0, t_nc = 16'd0;
    logic [6:0]  m_ctl = 7'd0;
    logic [3:0]  m_pre = 4'd0;
    logic        m_flag = 1'b0, m_strb = 1'b0;
    logic        t_tk, t_cw, t_zw, t_iw, t_fl, t_set, t_strb;

    function automatic logic [3:0] term(input logic [1:0] s);
        case (s)
            2'd0: return 4'd0;
            2'd1: return 4'd3;
            2'd2: return 4'd7;
            default: return 4'd15;
        endcase
    endfunction

    function automatic logic [15:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return m_ctl[2] ? m_load : m_cnt;
            2'd1: return {9'd0, m_ctl};
            2'd2: return {15'd0, m_flag};
            default: return 16'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_load = 0; m_ctl = 0; m_pre = 0; m_flag = 0; m_strb = 0;
        end else begin
            t_tk = m_ctl[0] && (m_pre == term(m_ctl[5:4]));
            t_cw = bus_wr && bus_addr == 2'd0 && bus_be != 2'b00;
            t_mv = m_ctl[1] ? m_load : m_cnt;
            if (bus_be[0]) t_mv[7:0] = bus_wdata[7:0];
            if (bus_be[1]) t_mv[15:8] = bus_wdata[15:8];
            t_zw = t_cw && (t_mv == 16'd0);
            t_iw = t_cw && (t_zw || !m_ctl[1]);
            t_fl = bus_wr && bus_addr == 2'd1 && bus_be[0] && bus_wdata[3];
            t_set = 1'b0;
            t_strb = t_zw && le && bf;
            t_nc = m_cnt;
            if (t_iw) t_nc = t_mv;
            else if (t_fl) t_nc = m_load;
            else if (t_tk && m_cnt != 16'd0) begin
                if (m_cnt == 16'd1) begin
                    t_nc = m_ctl[1] ? m_load : 16'd0;
                    t_set = 1'b1;
                    if (m_ctl[1] && le && bf) t_strb = 1'b1;
                end else begin
                    t_nc = m_cnt - 16'd1;
                end
            end
            m_pre = (t_iw || !m_ctl[0] || t_tk) ? 4'd0 : m_pre + 4'd1;
            if (t_cw) m_load = t_mv;
            m_cnt = t_nc;
            if (t_set) m_flag = 1'b1;
            else if (bus_wr && bus_addr == 2'd2 && bus_be[0] && bus_wdata[0]) m_flag = 1'b0;
            if (bus_wr && bus_addr == 2'd1 && bus_be[0]) m_ctl = bus_wdata[6:0] & 7'h77;
            m_strb = t_strb;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp();
        chk("R3 read data", 32'(bus_rdata), 32'(exp_rdata(bus_addr)));
        chk("R10 zero flag", 32'(zero_flag), 32'(m_flag));
        chk("R11 irq", 32'(irq), 32'(m_flag & m_ctl[6]));
        chk("R8 latch pulse", 32'(pulse), 32'(m_strb));
    endtask

    task automatic step(input logic [1:0] a, input logic w, input logic [1:0] be, input logic [15:0] d);
        bus_addr = a; bus_wr = w; bus_be = be; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        cmp();
    endtask

    task automatic wr_cnt(input logic [15:0] d, input logic [1:0] be);
        step(2'd0, 1'b1, be, d);
    endtask

    task automatic wr_ctl(input logic [6:0] d);
        step(2'd1, 1'b1, 2'b01, {9'd0, d});
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(2'd0, 1'b0, 2'b00, 16'd0);
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] d;
        int r;
        void'($urandom(32'h1D2C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            chk("R1 location after reset", 32'(v), 32'd0);
        end
        chk("R1 zero flag after reset", 32'(zero_flag), 32'd0);
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R1 pulse after reset", 32'(pulse), 32'd0);

        // R2: word and byte writes, one-shot mode, halted
        wr_cnt(16'h1234, 2'b11);
        peek(2'd0, v); chk("R2 word write", 32'(v), 32'h1234);
        wr_cnt(16'hAB00, 2'b10);
        peek(2'd0, v); chk("R2 high byte write", 32'(v), 32'hAB34);
        wr_cnt(16'h0056, 2'b01);
        peek(2'd0, v); chk("R2 low byte write", 32'(v), 32'hAB56);

        // R9: divide by 4, then halt
        wr_ctl(7'h11);
        wr_cnt(16'd100, 2'b11);
        idle(8);
        peek(2'd0, v); chk("R9 div4 after 8 clocks", 32'(v), 32'd98);
        wr_ctl(7'h10);
        idle(10);
        peek(2'd0, v); chk("R9 halted count", 32'(v), 32'd98);

        // R6: one-shot run to zero
        wr_ctl(7'h01);
        wr_cnt(16'd3, 2'b11);
        idle(3);
        peek(2'd0, v); chk("R6 reached zero", 32'(v), 32'd0);
        chk("R6 flag on arrival", 32'(zero_flag), 32'd1);
        idle(4);
        peek(2'd0, v); chk("R6 rests at zero", 32'(v), 32'd0);
        step(2'd2, 1'b1, 2'b01, 16'd1);
        idle(4);
        chk("R6 no second flag", 32'(zero_flag), 32'd0);

        // R7 and R8: zero write parks and strobes
        le = 1'b1; bf = 1'b1;
        wr_cnt(16'd5, 2'b11);
        idle(1);
        wr_cnt(16'd0, 2'b11);
        chk("R8 strobe after zero write", 32'(pulse), 32'd1);
        chk("R7 no flag on zero write", 32'(zero_flag), 32'd0);
        idle(1);
        chk("R8 strobe lasts one cycle", 32'(pulse), 32'd0);
        idle(3);
        peek(2'd0, v); chk("R7 parked at zero", 32'(v), 32'd0);
        chk("R7 flag still clear", 32'(zero_flag), 32'd0);
        bf = 1'b0;
        wr_cnt(16'd0, 2'b11);
        chk("R8 no strobe without buffer enable", 32'(pulse), 32'd0);
        bf = 1'b1;

        // R4, R3, R5: deferred load, read select, force load
        wr_ctl(7'h02);
        wr_cnt(16'd50, 2'b11);
        peek(2'd0, v); chk("R4 count untouched by modulus write", 32'(v), 32'd0);
        wr_ctl(7'h06);
        peek(2'd0, v); chk("R3 read selects load register", 32'(v), 32'd50);
        wr_ctl(7'h0A);
        peek(2'd0, v); chk("R5 force copies load", 32'(v), 32'd50);
        peek(2'd1, v); chk("R5 force bit reads zero", 32'(v), 32'h02);

        // R10 and R11: modulus underflow and reload
        wr_cnt(16'd2, 2'b11);
        wr_ctl(7'h0A);
        wr_cnt(16'd7, 2'b11);
        peek(2'd0, v); chk("R4 count keeps old value", 32'(v), 32'd2);
        wr_ctl(7'h43);
        idle(2);
        peek(2'd0, v); chk("R10 reload on underflow", 32'(v), 32'd7);
        chk("R10 flag on underflow", 32'(zero_flag), 32'd1);
        chk("R11 irq with enable", 32'(irq), 32'd1);
        chk("R8 strobe on modulus underflow", 32'(pulse), 32'd1);
        idle(1);
        peek(2'd0, v); chk("R10 counts on after reload", 32'(v), 32'd6);
        step(2'd2, 1'b1, 2'b01, 16'd1);
        chk("R11 flag cleared", 32'(zero_flag), 32'd0);
        chk("R11 irq dropped", 32'(irq), 32'd0);
        idle(4);
        wr_cnt(16'd9, 2'b11);
        peek(2'd0, v); chk("R4 reload uses value before write", 32'(v), 32'd7);
        wr_ctl(7'h06);
        peek(2'd0, v); chk("R4 new load stored", 32'(v), 32'd9);

        // Random phase against the reference state (R2..R11)
        for (int i = 0; i < 5000; i++) begin
            le = 1'($urandom % 2);
            bf = 1'($urandom % 2);
            r = int'($urandom % 16);
            case ($urandom % 8)
                0: d = 16'd0;
                1: d = 16'($urandom);
                default: d = 16'($urandom % 24);
            endcase
            if (r < 3) begin
                wr_cnt(d, 2'(1 + $urandom % 3));
            end else if (r == 3) begin
                d = 16'($urandom % 128);
                if ($urandom % 4 != 0) d[3] = 1'b0;
                if ($urandom % 3 != 0) d[0] = 1'b1;
                wr_ctl(d[6:0]);
            end else if (r == 4) begin
                step(2'd2, 1'b1, 2'(1 + $urandom % 3), 16'($urandom % 2));
            end else begin
                step(2'($urandom % 4), 1'b0, 2'b00, 16'd0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule